// File: doc/BRIEF.md
# Prioritised IRQ/FIQ interrupt controller

This block gathers seventeen interrupt sources and drives the two interrupt inputs of a processor core: a normal request line and a fast request line. There are ten on-chip peripheral lines, one external pin and a six-line bus from programmable logic. Every source has an enable bit, a six-bit priority and a routing bit that sends it to either the normal or the fast output. An output rises whenever at least one source routed to it is pending, enabled and has a nonzero priority.

Peripheral lines are level-sensitive. They pass through a two-flop synchroniser and then set a sticky flag that only software can clear. The external pin uses the same synchroniser but is not latched. The six-line bus can be read in three ways, selected by a register. In the first, it is six separate requests. In the second, it is one request whose priority is the whole six-bit value. In the third, bit 0 is the request and the upper five bits are its priority.

For each output, a read-only register reports the winning source and its priority. Software reads this register after the output rises to decide which handler to run. Software then clears the peripheral flag.

Top module: `prio_intc`

## Requirements
- R1: Source numbering: peripheral lines are sources 0 to 9, the external pin is source 10, and programmable-logic lines 0 to 5 are sources 11 to 16.
- R2: ROUTE register (address 0x01) bit i set sends source i to `fiq_o`; bit i clear sends it to `irq_o`. A source never contributes to both outputs.
- R3: `irq_o` (or `fiq_o`) is registered. It is high on the cycle after a cycle in which at least one active source routed to it existed, and low otherwise.
- R4: MODE register (address 0x02, bits 1:0) sets how the six-line bus is read. Value 1: any nonzero bus value is a request on source 11, with priority equal to the bus value. Value 2: bus bit 0 is a request on source 11, with priority equal to bus bits 5:1. In modes 1 and 2, sources 12 to 16 are never pending. Values 0 and 3: each bus line is its own source (11 to 16), using its programmed priority.
- R5: A peripheral or external input that goes high is visible in PEND (address 0x03) after the third rising edge counted from the input change, that is, after two synchroniser edges plus the flag edge for peripherals. The external pin is visible after two edges and is not latched. When the pin drops, its PEND bit drops after two edges.
- R6: A peripheral PEND bit stays set after its input drops, until software writes 1 to that bit of PEND. Writing 0 has no effect. If the synchronised input is still high during the clearing write, the flag stays set.
- R7: IRQ_TOP (0x05) and FIQ_TOP (0x06) report the winning source: bit 31 is valid, bits 12:8 are the source number and bits 5:0 are the priority. The winner is the active source with the highest priority; on equal priority, the lower source number wins. The register reads zero when no source is active.
- R8: A source is active only when it is pending, its ENABLE bit (0x00, 1 = allowed) is set, and its effective priority is nonzero. A priority of zero behaves exactly like a cleared enable bit. ACTIVE (0x04) shows this set of sources.
- R9: After reset, every register reads zero and both outputs are low.
- R10: PRIO registers sit at 0x20 + source number and hold 6 bits. ENABLE, ROUTE and MODE read back the value last written. Register reads are combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_irq_i | input | 10 | Level interrupt lines from on-chip peripherals |
| ext_irq_i | input | 1 | External interrupt pin, asynchronous |
| pl_irq_i | input | 6 | Interrupt bus from programmable logic, synchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_o | output | 1 | Normal interrupt request to the core |
| fiq_o | output | 1 | Fast interrupt request to the core |

## Verification
Two functions can fall in the same cycle: a software write-one-to-clear of a peripheral flag, and the synchronised level of that same line setting the flag again. The bench provokes this by clearing a flag while its input is still held high. The behavioural model expects the set to win, so the flag must still read as pending afterwards. The bench also changes the enable, priority and mode registers while sources are pending. In that case, the registered output and the combinational winner register have to move on different cycles, and the model compares both on every clock.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

   typedef enum logic [1:0] {
      PLM_SPLIT  = 2'd0,
      PLM_CODED  = 2'd1,
      PLM_REQPRI = 2'd2
   } plm_e;

   localparam int unsigned A_ENABLE   = 0;
   localparam int unsigned A_ROUTE    = 1;
   localparam int unsigned A_MODE     = 2;
   localparam int unsigned A_PEND     = 3;
   localparam int unsigned A_ACTIVE   = 4;
   localparam int unsigned A_IRQTOP   = 5;
   localparam int unsigned A_FIQTOP   = 6;

   localparam int unsigned TOP_VALID_BIT = 31;
   localparam int unsigned TOP_ID_LSB    = 8;

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_err_stages
      $error("intc_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= d_i;
         for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/intc_flags.sv
module intc_flags #(
   parameter int unsigned W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] flag_o
);
   logic [W-1:0] flag_q;

   // a set in the same cycle as a clear keeps the flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= set_i | (flag_q & ~clr_i);
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/intc_pl_decode.sv
module intc_pl_decode
   import prio_intc_pkg::*;
#(
   parameter int unsigned PLW = 6,
   parameter int unsigned PW  = 6
) (
   input  logic [1:0]     mode_i,
   input  logic [PLW-1:0] bus_i,
   output logic [PLW-1:0] req_o,
   output logic [PW-1:0]  prio_o,
   output logic           coded_o
);
   if (PW < PLW) begin : g_err_width
      $error("intc_pl_decode: PW must hold a full bus value");
   end

   always_comb begin
      req_o   = '0;
      prio_o  = '0;
      coded_o = 1'b0;
      case (mode_i)
         PLM_CODED: begin
            coded_o  = 1'b1;
            req_o[0] = |bus_i;
            prio_o   = PW'(bus_i);
         end
         PLM_REQPRI: begin
            coded_o  = 1'b1;
            req_o[0] = bus_i[0];
            prio_o   = PW'(bus_i[PLW-1:1]);
         end
         default: req_o = bus_i;
      endcase
   end
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
   parameter int unsigned N   = 17,
   parameter int unsigned PW  = 6,
   parameter int unsigned IDW = 5
) (
   input  logic [N-1:0]    cand_i,
   input  logic [N*PW-1:0] prio_i,
   output logic            valid_o,
   output logic [IDW-1:0]  id_o,
   output logic [PW-1:0]   prio_o
);
   // strict greater-than keeps the lowest index among equals
   always_comb begin
      valid_o = 1'b0;
      id_o    = '0;
      prio_o  = '0;
      for (int i = 0; i < int'(N); i++) begin
         if (cand_i[i] && (prio_i[i*PW +: PW] > prio_o)) begin
            valid_o = 1'b1;
            id_o    = IDW'(i);
            prio_o  = prio_i[i*PW +: PW];
         end
      end
   end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
   import prio_intc_pkg::*;
#(
   parameter int unsigned NPERIPH     = 10,
   parameter int unsigned PLW         = 6,
   parameter int unsigned PW          = 6,
   parameter int unsigned AW          = 6,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NPERIPH-1:0] periph_irq_i,
   input  logic               ext_irq_i,
   input  logic [PLW-1:0]     pl_irq_i,
   input  logic               reg_we,
   input  logic [AW-1:0]      reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic               irq_o,
   output logic               fiq_o
);
   localparam int unsigned NSRC   = NPERIPH + 1 + PLW;
   localparam int unsigned EXT_IX = NPERIPH;
   localparam int unsigned PL_IX  = NPERIPH + 1;
   localparam int unsigned IDW    = $clog2(NSRC);

   if (NSRC > 32)                 begin : g_err_nsrc $error("prio_intc: too many sources"); end
   if (AW < 6)                    begin : g_err_aw   $error("prio_intc: AW too small"); end
   if (PLW < 2)                   begin : g_err_plw  $error("prio_intc: PLW must be at least 2"); end
   if (PW < PLW)                  begin : g_err_pw   $error("prio_intc: PW below PLW"); end
   if (PW > TOP_ID_LSB)           begin : g_err_pwf  $error("prio_intc: PW overlaps id field"); end
   if (TOP_ID_LSB + IDW > TOP_VALID_BIT) begin : g_err_idf $error("prio_intc: id field too wide"); end

   // configuration state
   logic [NSRC-1:0] en_q, route_q;
   logic [1:0]      mode_q;
   logic [PW-1:0]   prio_q [NSRC];

   // source front end
   logic [NPERIPH:0]   sync_lvl;
   logic [NPERIPH-1:0] pflag, flag_clr;
   logic [PLW-1:0]     pl_req;
   logic [PW-1:0]      pl_prio;
   logic               pl_coded;
   logic [NSRC-1:0]    pend, prio_nz, active;
   logic [NSRC*PW-1:0] eff_prio;

   // arbitration
   logic [1:0][NSRC-1:0] cand;
   logic [1:0]           top_valid;
   logic [1:0][IDW-1:0]  top_id;
   logic [1:0][PW-1:0]   top_prio;
   logic                 irq_q, fiq_q;

   // register decode
   logic           wr_pend, is_prio, prio_hit;
   logic [IDW-1:0] pidx;
   logic           unused_wdata;

   assign unused_wdata = ^reg_wdata[31:NSRC];

   intc_sync #(.W(NPERIPH + 1), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({ext_irq_i, periph_irq_i}),
      .q_o   (sync_lvl)
   );

   assign wr_pend  = reg_we && (reg_addr == AW'(A_PEND));
   assign flag_clr = wr_pend ? reg_wdata[NPERIPH-1:0] : '0;

   intc_flags #(.W(NPERIPH)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (sync_lvl[NPERIPH-1:0]),
      .clr_i  (flag_clr),
      .flag_o (pflag)
   );

   intc_pl_decode #(.PLW(PLW), .PW(PW)) u_pl (
      .mode_i  (mode_q),
      .bus_i   (pl_irq_i),
      .req_o   (pl_req),
      .prio_o  (pl_prio),
      .coded_o (pl_coded)
   );

   assign pend = {pl_req, sync_lvl[EXT_IX], pflag};

   for (genvar i = 0; i < NSRC; i++) begin : g_eprio
      if (i == PL_IX) begin : g_plsrc
         assign eff_prio[i*PW +: PW] = pl_coded ? pl_prio : prio_q[i];
      end else begin : g_plain
         assign eff_prio[i*PW +: PW] = prio_q[i];
      end
      assign prio_nz[i] = |eff_prio[i*PW +: PW];
   end

   assign active  = pend & en_q & prio_nz;
   assign cand[0] = active & ~route_q;
   assign cand[1] = active & route_q;

   for (genvar o = 0; o < 2; o++) begin : g_pick
      intc_pick #(.N(NSRC), .PW(PW), .IDW(IDW)) u_pick (
         .cand_i  (cand[o]),
         .prio_i  (eff_prio),
         .valid_o (top_valid[o]),
         .id_o    (top_id[o]),
         .prio_o  (top_prio[o])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         fiq_q <= 1'b0;
      end else begin
         irq_q <= |cand[0];
         fiq_q <= |cand[1];
      end
   end

   assign irq_o = irq_q;
   assign fiq_o = fiq_q;

   assign is_prio  = (reg_addr[AW-1:5] == (AW-5)'(1));
   assign prio_hit = is_prio && (int'(reg_addr[4:0]) < int'(NSRC));
   assign pidx     = reg_addr[IDW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= '0;
         route_q <= '0;
         mode_q  <= PLM_SPLIT;
         for (int i = 0; i < int'(NSRC); i++) prio_q[i] <= '0;
      end else if (reg_we) begin
         if (reg_addr == AW'(A_ENABLE)) en_q    <= reg_wdata[NSRC-1:0];
         if (reg_addr == AW'(A_ROUTE))  route_q <= reg_wdata[NSRC-1:0];
         if (reg_addr == AW'(A_MODE))   mode_q  <= reg_wdata[1:0];
         if (prio_hit)                  prio_q[pidx] <= reg_wdata[PW-1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (prio_hit) begin
         reg_rdata[PW-1:0] = prio_q[pidx];
      end else begin
         case (reg_addr)
            AW'(A_ENABLE): reg_rdata[NSRC-1:0] = en_q;
            AW'(A_ROUTE):  reg_rdata[NSRC-1:0] = route_q;
            AW'(A_MODE):   reg_rdata[1:0]      = mode_q;
            AW'(A_PEND):   reg_rdata[NSRC-1:0] = pend;
            AW'(A_ACTIVE): reg_rdata[NSRC-1:0] = active;
            AW'(A_IRQTOP): begin
               reg_rdata[TOP_VALID_BIT]       = top_valid[0];
               reg_rdata[TOP_ID_LSB +: IDW]   = top_id[0];
               reg_rdata[PW-1:0]              = top_prio[0];
            end
            AW'(A_FIQTOP): begin
               reg_rdata[TOP_VALID_BIT]       = top_valid[1];
               reg_rdata[TOP_ID_LSB +: IDW]   = top_id[1];
               reg_rdata[PW-1:0]              = top_prio[1];
            end
            default: reg_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
   parameter int unsigned NSRC = 17,
   parameter int unsigned NP   = 10,
   parameter int unsigned PW   = 6,
   parameter int unsigned IDW  = 5,
   parameter int unsigned AW   = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                irq_o,
   input logic                fiq_o,
   input logic [1:0]          top_valid,
   input logic [1:0][IDW-1:0] top_id,
   input logic [1:0][PW-1:0]  top_prio,
   input logic [NSRC-1:0]     route_q,
   input logic [NP-1:0]       pflag,
   input logic                reg_we,
   input logic [AW-1:0]       reg_addr,
   input logic [1:0]          mode_q,
   input logic [NSRC-1:0]     pend
);
   p_irq_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == $past(top_valid[0]));

   p_fiq_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_o == $past(top_valid[1]));

   p_irq_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
      top_valid[0] |-> !route_q[top_id[0]]);

   p_fiq_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
      top_valid[1] |-> route_q[top_id[1]]);

   p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(pflag) & ~pflag)) |-> $past(reg_we && (reg_addr == AW'(3))));

   p_irq_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
      top_valid[0] |-> (top_prio[0] != '0));

   p_fiq_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
      top_valid[1] |-> (top_prio[1] != '0));

   p_pl_unused_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == 2'd1) || (mode_q == 2'd2)) |-> (pend[NSRC-1:NP+2] == '0));
endmodule

bind prio_intc intc_chk #(
   .NSRC (NSRC),
   .NP   (NPERIPH),
   .PW   (PW),
   .IDW  (IDW),
   .AW   (AW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_o     (irq_o),
   .fiq_o     (fiq_o),
   .top_valid (top_valid),
   .top_id    (top_id),
   .top_prio  (top_prio),
   .route_q   (route_q),
   .pflag     (pflag),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .mode_q    (mode_q),
   .pend      (pend)
);

// File: tb/test_prio_intc.sv
module test_prio_intc;
   localparam int CLK_P = 10;
   localparam int NP    = 10;
   localparam int NS    = 17;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [9:0]  periph;
   logic        ext;
   logic [5:0]  pl;
   logic        we;
   logic [5:0]  addr;
   logic [31:0] wdata;
   logic [31:0] rdata;
   logic        irq, fiq;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #(CLK_P/2) clk = ~clk;

   prio_intc i_prio_intc (
      .clk (clk), .rst_n (rst_n), .periph_irq_i (periph), .ext_irq_i (ext),
      .pl_irq_i (pl), .reg_we (we), .reg_addr (addr), .reg_wdata (wdata),
      .reg_rdata (rdata), .irq_o (irq), .fiq_o (fiq)
   );

   // ---------------- behavioural reference ----------------
   bit [NP-1:0] m_s1, m_s2, m_flag;
   bit          m_e1, m_e2;
   bit [NS-1:0] m_en, m_route;
   bit [1:0]    m_mode;
   int          m_prio [NS];
   bit          m_irq, m_fiq;

   function automatic bit m_pend(int i);
      int k;
      if (i < NP) return m_flag[i];
      if (i == NP) return m_e2;
      k = i - NP - 1;
      if (m_mode == 2'd1) return (k == 0) && (pl != 6'd0);
      if (m_mode == 2'd2) return (k == 0) && pl[0];
      return pl[k];
   endfunction

   function automatic int m_eprio(int i);
      if (i == NP + 1 && m_mode == 2'd1) return int'(pl);
      if (i == NP + 1 && m_mode == 2'd2) return int'(pl >> 1);
      return m_prio[i];
   endfunction

   function automatic bit m_act(int i);
      return m_pend(i) && m_en[i] && (m_eprio(i) != 0);
   endfunction

   function automatic logic [31:0] m_top(bit want_fiq);
      int best = -1;
      int bp   = 0;
      for (int i = 0; i < NS; i++)
         if (m_act(i) && (m_route[i] == want_fiq) && (m_eprio(i) > bp)) begin
            best = i;
            bp   = m_eprio(i);
         end
      if (best < 0) return 32'd0;
      return 32'h8000_0000 | (32'(best) << 8) | 32'(bp);
   endfunction

   function automatic logic [31:0] m_read(logic [5:0] a);
      logic [31:0] v = '0;
      case (a)
         6'd0: v[NS-1:0] = m_en;
         6'd1: v[NS-1:0] = m_route;
         6'd2: v[1:0]    = m_mode;
         6'd3: for (int i = 0; i < NS; i++) v[i] = m_pend(i);
         6'd4: for (int i = 0; i < NS; i++) v[i] = m_act(i);
         6'd5: v = m_top(1'b0);
         6'd6: v = m_top(1'b1);
         default: if (a >= 6'd32 && int'(a) - 32 < NS) v = 32'(m_prio[int'(a) - 32]);
      endcase
      return v;
   endfunction

   always @(posedge clk) begin : model
      bit ni, nf;
      bit [NP-1:0] clr;
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_flag = '0; m_e1 = 0; m_e2 = 0;
         m_en = '0; m_route = '0; m_mode = '0; m_irq = 0; m_fiq = 0;
         for (int i = 0; i < NS; i++) m_prio[i] = 0;
      end else begin
         ni = 0; nf = 0;
         for (int i = 0; i < NS; i++)
            if (m_act(i)) begin
               if (m_route[i]) nf = 1; else ni = 1;
            end
         clr    = (we && addr == 6'd3) ? wdata[NP-1:0] : '0;
         m_irq  = ni;
         m_fiq  = nf;
         m_flag = m_s2 | (m_flag & ~clr);
         m_s2   = m_s1;
         m_s1   = periph;
         m_e2   = m_e1;
         m_e1   = ext;
         if (we) begin
            case (addr)
               6'd0: m_en    = wdata[NS-1:0];
               6'd1: m_route = wdata[NS-1:0];
               6'd2: m_mode  = wdata[1:0];
               default: if (addr >= 6'd32 && int'(addr) - 32 < NS)
                  m_prio[int'(addr) - 32] = int'(wdata[5:0]);
            endcase
         end
      end
   end

   // ---------------- check helpers ----------------
   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      chk("R3 irq_o per-cycle", 32'(irq), 32'(m_irq));
      chk("R3 fiq_o per-cycle", 32'(fiq), 32'(m_fiq));
      chk((addr == 6'd5 || addr == 6'd6) ? "R7 top per-cycle" : "R10 rdata per-cycle",
          rdata, m_read(addr));
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic wr(logic [5:0] a, logic [31:0] d);
      we = 1; addr = a; wdata = d;
      tick();
      we = 0;
   endtask

   task automatic rd(logic [5:0] a, logic [31:0] e, string tag);
      addr = a;
      #1;
      chk(tag, rdata, e);
   endtask

   // ---------------- stimulus ----------------
   initial begin
      rst_n = 0; periph = '0; ext = 0; pl = '0; we = 0; addr = '0; wdata = '0;
      repeat (3) @(negedge clk);
      chk("R9 irq_o reset", 32'(irq), 32'd0);
      chk("R9 fiq_o reset", 32'(fiq), 32'd0);
      rd(6'd5, 32'd0, "R9 IRQ_TOP reset");
      rd(6'd0, 32'd0, "R9 ENABLE reset");
      rd(6'd32, 32'd0, "R9 PRIO0 reset");
      rst_n = 1;
      ticks(2);

      // priorities and enables
      wr(6'd32, 32'd3);            // source 0
      wr(6'd36, 32'd3);            // source 4
      wr(6'd42, 32'd7);            // source 10
      wr(6'd45, 32'd5);            // source 13
      rd(6'd36, 32'd3, "R10 PRIO4 readback");
      wr(6'd0, 32'h1FFFF);
      rd(6'd0, 32'h1FFFF, "R10 ENABLE readback");

      // R1 R5 R3 R7: two peripherals, equal priority
      periph = 10'h011;
      ticks(2);
      rd(6'd3, 32'h0, "R5 PEND not yet after two edges");
      tick();
      rd(6'd3, 32'h11, "R5 PEND after three edges");
      chk("R3 irq_o still low", 32'(irq), 32'd0);
      tick();
      chk("R3 irq_o rises", 32'(irq), 32'd1);
      rd(6'd5, 32'h8000_0003, "R7 tie goes to lower index");

      // R6 sticky flags and clearing
      periph = '0;
      ticks(3);
      rd(6'd3, 32'h11, "R6 flags held after input drop");
      wr(6'd3, 32'h0);
      rd(6'd3, 32'h11, "R6 writing zero ignored");
      wr(6'd3, 32'h1);
      rd(6'd3, 32'h10, "R6 clear bit 0");
      rd(6'd5, 32'h8000_0403, "R7 next winner source 4");
      wr(6'd3, 32'h10);
      rd(6'd3, 32'h0, "R6 clear bit 4");
      chk("R3 irq_o one cycle late", 32'(irq), 32'd1);
      tick();
      chk("R3 irq_o falls", 32'(irq), 32'd0);

      // R8 zero priority and enable
      periph = 10'h004;
      ticks(3);
      rd(6'd3, 32'h4, "R8 pending with prio zero");
      rd(6'd4, 32'h0, "R8 prio zero not active");
      wr(6'd34, 32'd5);
      rd(6'd4, 32'h4, "R8 active once prio set");
      wr(6'd0, 32'h1FFFB);
      rd(6'd4, 32'h0, "R8 enable clear blocks");
      // R6 clear collides with a still-high line
      wr(6'd3, 32'h4);
      rd(6'd3, 32'h4, "R6 set wins over clear");
      periph = '0;
      ticks(3);
      wr(6'd3, 32'h4);
      rd(6'd3, 32'h0, "R6 cleared after drop");
      wr(6'd0, 32'h1FFFF);

      // R2 R5 external pin on the fast line
      wr(6'd1, 32'h400);
      rd(6'd1, 32'h400, "R10 ROUTE readback");
      ext = 1;
      ticks(2);
      rd(6'd3, 32'h400, "R5 ext pending after two edges");
      tick();
      chk("R2 fiq_o high", 32'(fiq), 32'd1);
      chk("R2 irq_o low", 32'(irq), 32'd0);
      rd(6'd6, 32'h8000_0A07, "R7 FIQ_TOP ext");
      rd(6'd5, 32'h0, "R2 IRQ_TOP empty");
      ext = 0;
      ticks(2);
      rd(6'd3, 32'h0, "R5 ext not latched");
      ticks(2);

      // R4 bus modes
      pl = 6'b000100;
      rd(6'd3, 32'h2000, "R1 split line 2 is source 13");
      rd(6'd5, 32'h8000_0D05, "R7 split winner");
      tick();
      chk("R3 irq_o from bus", 32'(irq), 32'd1);
      pl = '0;
      wr(6'd2, 32'd1);
      rd(6'd2, 32'd1, "R10 MODE readback");
      pl = 6'h2A;
      rd(6'd3, 32'h800, "R4 coded request on 11");
      rd(6'd5, 32'h8000_0B2A, "R4 coded priority");
      pl = 6'h00;
      rd(6'd3, 32'h0, "R4 coded zero no request");
      pl = 6'h3F;
      rd(6'd3, 32'h800, "R4 lines 12-16 idle in coded mode");
      tick();
      wr(6'd2, 32'd2);
      pl = 6'b100111;
      rd(6'd5, 32'h8000_0B13, "R4 request bit plus 5-bit priority");
      pl = 6'b111110;
      rd(6'd3, 32'h0, "R4 no request bit");
      pl = 6'b000001;
      rd(6'd3, 32'h800, "R4 request with zero priority pending");
      rd(6'd4, 32'h0, "R8 bus priority zero inactive");
      tick();
      pl = '0;
      wr(6'd2, 32'd3);
      pl = 6'b100000;
      rd(6'd3, 32'h1_0000, "R4 mode 3 acts as split");
      ticks(3);
      pl = '0;
      ticks(3);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule